// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Timer

This block chooses which of two programmed charge-pump current codes drives the loop while a synthesizer changes frequency. Software keeps a boost flag, the gain bit, which it sets when it programs a new divider value. While the flag is set, the output carries the secondary (boosted) current code. Otherwise it carries the primary (steady-state) code.

Two control bits and a four-bit timeout code set what ends the boost. In manual mode the flag stays set until software writes it back to zero. In timed mode a down-counter runs on an external timing tick. When the counter expires it clears the stored flag by itself, sends a one-cycle notice, and leaves the block ready for the next frequency change. A power-down input holds the counter at its load value. The analog pump and the PLL dividers are outside this block.

Top module: `fl_current_timer`

## Requirements
- R1: After synchronous reset, `gain_bit` is 0, `auto_clr` is 0 and `cp_cur` equals `cur_primary`.
- R2: `cp_cur` equals `cur_secondary` while `gain_bit` is 1 and `cur_primary` while it is 0. This holds in every mode.
- R3: A cycle with `gain_wr` high loads `gain_wr_val` into `gain_bit`. The new value is visible after that clock edge.
- R4: With `fl_enable`=1 and `fl_mode`=0 (manual), `gain_bit` stays 1 through any number of ticks and `auto_clr` never pulses.
- R5: With `fl_enable`=1 and `fl_mode`=1 (timed), `gain_bit` clears by itself on the clock edge that carries the (code+1)*4-th tick after the write of 1. `auto_clr` is 1 for that one cycle. The tests use codes 0, 2 and 15.
- R6: Only cycles with `tick` high advance the timeout. Sparse ticks give the same tick count.
- R7: A new write of 1 while the timer runs reloads the full timeout.
- R8: With `fl_enable`=0, no automatic clearing takes place, whatever `fl_mode` is.
- R9: While `power_down` is 1, the timer is held at its load value and cannot expire. After release, a full timeout is counted again.
- R10: A software write in the cycle the timer would expire wins. `gain_bit` takes the written value and `auto_clr` stays 0.
- R11: `auto_clr` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fl_enable | input | 1 | Fastlock enable |
| fl_mode | input | 1 | 0 = manual exit, 1 = timed exit |
| timeout_code | input | 4 | Timeout length code, (code+1)*4 ticks |
| cur_primary | input | 3 | Steady-state current code |
| cur_secondary | input | 3 | Boosted current code |
| gain_wr | input | 1 | Software write strobe for the gain bit |
| gain_wr_val | input | 1 | Value written to the gain bit |
| tick | input | 1 | Timeout time-base tick |
| power_down | input | 1 | Holds the timer at its load value |
| cp_cur | output | 3 | Selected current code |
| gain_bit | output | 1 | Stored gain bit |
| auto_clr | output | 1 | One-cycle pulse when the timer clears the gain bit |

## Verification
The hardest case to reach is the collision of a software write with the timer's expiry edge. The stimulus runs a short timeout with a tick on every cycle, counting edges from the write. It then places a second write exactly on the edge where the count reaches its last tick. Power-down is also raised partway through a running timeout. The check is that, after release, a complete fresh period is counted and not the remainder.

// File: rtl/fl_pkg.sv
package fl_pkg;

    localparam int FL_CODE_W_DEF = 4;
    localparam int FL_CUR_W_DEF  = 3;
    localparam int FL_STEP_DEF   = 4;

    typedef enum logic {
        FL_MODE_MANUAL = 1'b0,
        FL_MODE_TIMED  = 1'b1
    } fl_mode_e;

    typedef struct packed {
        logic run;   // timed mode active with gain set
        logic hold;  // power-down: stay at load state
        logic load;  // software write of 1: restart period
    } fl_ctl_t;

    function automatic logic timed_active(logic en, logic mode);
        return en && (fl_mode_e'(mode) == FL_MODE_TIMED);
    endfunction

endpackage

// File: rtl/fl_timeout_counter.sv
module fl_timeout_counter
    import fl_pkg::*;
#(
    parameter int CODE_W = FL_CODE_W_DEF,
    parameter int STEP   = FL_STEP_DEF,
    parameter int CNT_W  = $clog2((2**CODE_W) * STEP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  fl_ctl_t           ctl,
    input  logic              tick,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             at_last;
    logic             restart;

    assign load_val = (CNT_W'(code) + CNT_W'(1)) * CNT_W'(STEP);
    assign at_last  = (cnt_q == CNT_W'(1));
    assign restart  = ctl.load || ctl.hold || !ctl.run;
    assign expire   = !restart && tick && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= load_val;
        end else if (restart) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (at_last) begin
                cnt_q <= load_val;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/fl_gain_reg.sv
module fl_gain_reg (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wr_val,
    input  logic expire,
    output logic gain_q,
    output logic auto_clr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q     <= 1'b0;
            auto_clr_q <= 1'b0;
        end else begin
            auto_clr_q <= expire && !wr;
            if (wr) begin
                gain_q <= wr_val;
            end else if (expire) begin
                gain_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fl_current_mux.sv
module fl_current_mux #(
    parameter int CUR_W = 3
) (
    input  logic             sel_boost,
    input  logic [CUR_W-1:0] cur_lo,
    input  logic [CUR_W-1:0] cur_hi,
    output logic [CUR_W-1:0] cur_out
);

    always_comb begin
        cur_out = sel_boost ? cur_hi : cur_lo;
    end

endmodule

// File: rtl/fl_current_timer.sv
module fl_current_timer
    import fl_pkg::*;
#(
    parameter int CODE_W = FL_CODE_W_DEF,
    parameter int CUR_W  = FL_CUR_W_DEF,
    parameter int STEP   = FL_STEP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fl_enable,
    input  logic              fl_mode,
    input  logic [CODE_W-1:0] timeout_code,
    input  logic [CUR_W-1:0]  cur_primary,
    input  logic [CUR_W-1:0]  cur_secondary,
    input  logic              gain_wr,
    input  logic              gain_wr_val,
    input  logic              tick,
    input  logic              power_down,
    output logic [CUR_W-1:0]  cp_cur,
    output logic              gain_bit,
    output logic              auto_clr
);

    localparam int CNT_W = $clog2((2**CODE_W) * STEP + 1);

    fl_ctl_t ctl;
    logic    expire;

    always_comb begin
        ctl.run  = timed_active(fl_enable, fl_mode) && gain_bit;
        ctl.hold = power_down;
        ctl.load = gain_wr && gain_wr_val;
    end

    fl_timeout_counter #(
        .CODE_W (CODE_W),
        .STEP   (STEP),
        .CNT_W  (CNT_W)
    ) tmr_i (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .tick   (tick),
        .code   (timeout_code),
        .expire (expire)
    );

    fl_gain_reg gain_i (
        .clk        (clk),
        .rst        (rst),
        .wr         (gain_wr),
        .wr_val     (gain_wr_val),
        .expire     (expire),
        .gain_q     (gain_bit),
        .auto_clr_q (auto_clr)
    );

    fl_current_mux #(.CUR_W(CUR_W)) mux_i (
        .sel_boost (gain_bit),
        .cur_lo    (cur_primary),
        .cur_hi    (cur_secondary),
        .cur_out   (cp_cur)
    );

endmodule

// File: rtl/fl_current_timer_chk.sv
module fl_current_timer_chk #(
    parameter int CUR_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             fl_enable,
    input logic             fl_mode,
    input logic [CUR_W-1:0] cur_primary,
    input logic [CUR_W-1:0] cur_secondary,
    input logic             gain_wr,
    input logic             gain_wr_val,
    input logic             tick,
    input logic             power_down,
    input logic [CUR_W-1:0] cp_cur,
    input logic             gain_bit,
    input logic             auto_clr
);

    // R2
    cur_select_chk: assert property (@(posedge clk) disable iff (rst)
        cp_cur == (gain_bit ? cur_secondary : cur_primary));

    // R3
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        gain_wr |=> (gain_bit == $past(gain_wr_val)));

    // R5
    clr_falls_chk: assert property (@(posedge clk) disable iff (rst)
        auto_clr |-> $fell(gain_bit));

    // R4
    clr_timed_only_chk: assert property (@(posedge clk) disable iff (rst)
        auto_clr |-> $past(fl_mode));

    // R8
    clr_enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
        auto_clr |-> $past(fl_enable));

    // R6
    clr_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        auto_clr |-> $past(tick));

    // R9
    pd_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
        power_down |=> !auto_clr);

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        gain_wr |=> !auto_clr);

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        auto_clr |=> !auto_clr);

endmodule

bind fl_current_timer fl_current_timer_chk #(.CUR_W(CUR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .fl_enable     (fl_enable),
    .fl_mode       (fl_mode),
    .cur_primary   (cur_primary),
    .cur_secondary (cur_secondary),
    .gain_wr       (gain_wr),
    .gain_wr_val   (gain_wr_val),
    .tick          (tick),
    .power_down    (power_down),
    .cp_cur        (cp_cur),
    .gain_bit      (gain_bit),
    .auto_clr      (auto_clr)
);

// File: tb/fl_current_timer_tb.sv
module fl_current_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       fl_enable, fl_mode;
    logic [3:0] timeout_code;
    logic [2:0] cur_primary, cur_secondary;
    logic       gain_wr, gain_wr_val, tick, power_down;
    logic [2:0] cp_cur;
    logic       gain_bit, auto_clr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fl_current_timer dut_i (
        .clk(clk), .rst(rst), .fl_enable(fl_enable), .fl_mode(fl_mode),
        .timeout_code(timeout_code), .cur_primary(cur_primary),
        .cur_secondary(cur_secondary), .gain_wr(gain_wr),
        .gain_wr_val(gain_wr_val), .tick(tick), .power_down(power_down),
        .cp_cur(cp_cur), .gain_bit(gain_bit), .auto_clr(auto_clr)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // advance one clock; sample 1 ns after the edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sw_write(input logic v);
        gain_wr = 1'b1; gain_wr_val = v;
        step();
        gain_wr = 1'b0;
    endtask

    task automatic cfg(input logic en, input logic md, input logic [3:0] c);
        fl_enable = en; fl_mode = md; timeout_code = c;
        sw_write(1'b0);
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
        chk(gain_bit, 0, "R1 gain");
        chk(auto_clr, 0, "R1 auto_clr");
        chk(cp_cur, cur_primary, "R1 cp_cur");
    endtask

    task automatic t_write_select();
        cfg(1'b1, 1'b0, 4'd0);
        tick = 1'b0;
        sw_write(1'b1);
        chk(gain_bit, 1, "R3 set");
        chk(cp_cur, cur_secondary, "R2 boosted");
        cur_secondary = 3'd1; #1;
        chk(cp_cur, 1, "R2 follows secondary");
        sw_write(1'b0);
        chk(gain_bit, 0, "R3 clear");
        chk(cp_cur, cur_primary, "R2 primary");
        cur_secondary = 3'd6;
    endtask

    task automatic t_manual();
        cfg(1'b1, 1'b0, 4'd0);
        tick = 1'b1;
        sw_write(1'b1);
        for (int i = 0; i < 80; i++) begin
            step();
            if (auto_clr) chk(auto_clr, 0, "R4 no pulse");
        end
        chk(gain_bit, 1, "R4 still set");
        chk(cp_cur, cur_secondary, "R4 boosted");
        sw_write(1'b0);
        chk(gain_bit, 0, "R4 sw exit");
    endtask

    task automatic t_disabled();
        cfg(1'b0, 1'b1, 4'd0);
        tick = 1'b1;
        sw_write(1'b1);
        for (int i = 0; i < 80; i++) begin
            step();
            if (auto_clr) chk(auto_clr, 0, "R8 no pulse");
        end
        chk(gain_bit, 1, "R8 still set");
        chk(cp_cur, cur_secondary, "R8 boosted");
        sw_write(1'b0);
    endtask

    task automatic t_timed(input logic [3:0] c);
        int len = (int'(c) + 1) * 4;
        cfg(1'b1, 1'b1, c);
        tick = 1'b1;
        sw_write(1'b1);
        for (int i = 0; i < len - 1; i++) step();
        chk(gain_bit, 1, "R5 before expiry");
        chk(auto_clr, 0, "R5 no early pulse");
        step();
        chk(gain_bit, 0, "R5 cleared");
        chk(auto_clr, 1, "R5 pulse");
        chk(cp_cur, cur_primary, "R5 primary again");
        step();
        chk(auto_clr, 0, "R11 pulse ends");
        chk(gain_bit, 0, "R5 stays clear");
    endtask

    task automatic t_sparse();
        cfg(1'b1, 1'b1, 4'd1);
        tick = 1'b0;
        sw_write(1'b1);
        for (int i = 0; i < 7; i++) begin
            tick = 1'b1; step(); tick = 1'b0;
            step(); step();
        end
        chk(gain_bit, 1, "R6 after 7 ticks");
        tick = 1'b1; step(); tick = 1'b0;
        chk(gain_bit, 0, "R6 cleared on 8th tick");
        chk(auto_clr, 1, "R6 pulse");
        step();
        chk(auto_clr, 0, "R11 sparse pulse ends");
    endtask

    task automatic t_reload();
        cfg(1'b1, 1'b1, 4'd0);
        tick = 1'b1;
        sw_write(1'b1);
        step(); step();
        sw_write(1'b1);
        step(); step(); step();
        chk(gain_bit, 1, "R7 reloaded");
        step();
        chk(gain_bit, 0, "R7 full period");
        chk(auto_clr, 1, "R7 pulse");
    endtask

    task automatic t_collide();
        cfg(1'b1, 1'b1, 4'd0);
        tick = 1'b1;
        sw_write(1'b1);
        step(); step(); step();
        sw_write(1'b1);
        chk(gain_bit, 1, "R10 write wins");
        chk(auto_clr, 0, "R10 no pulse");
        step(); step(); step();
        chk(gain_bit, 1, "R10 reloaded");
        step();
        chk(gain_bit, 0, "R10 later expiry");
        sw_write(1'b1);
        step(); step(); step();
        sw_write(1'b0);
        chk(gain_bit, 0, "R10 write 0 on expiry");
        chk(auto_clr, 0, "R10 no pulse on write 0");
    endtask

    task automatic t_power_down();
        cfg(1'b1, 1'b1, 4'd0);
        tick = 1'b1;
        sw_write(1'b1);
        step(); step();
        power_down = 1'b1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (auto_clr) chk(auto_clr, 0, "R9 no pulse in pd");
        end
        chk(gain_bit, 1, "R9 held in pd");
        power_down = 1'b0;
        step(); step(); step();
        chk(gain_bit, 1, "R9 full period after pd");
        step();
        chk(gain_bit, 0, "R9 expiry after pd");
        chk(auto_clr, 1, "R9 pulse");
    endtask

    initial begin
        rst = 1'b1; fl_enable = 1'b0; fl_mode = 1'b0; timeout_code = '0;
        cur_primary = 3'd2; cur_secondary = 3'd6;
        gain_wr = 1'b0; gain_wr_val = 1'b0; tick = 1'b0; power_down = 1'b0;
        t_reset();
        t_write_select();
        t_manual();
        t_disabled();
        t_timed(4'd0);
        t_timed(4'd2);
        t_timed(4'd15);
        t_sparse();
        t_reload();
        t_collide();
        t_power_down();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule